// File: doc/BRIEF.md
# Paged Address Translator With Protection

This block turns a logical address into a physical address, given the page-table entry that software or a walker has already fetched for the page being touched. The logical address is cut into a page number (upper bits) and a byte offset within the page (lower bits). The page number is checked against the number of pages the running process owns. The entry's valid flag and its access rights are then checked against the kind of access. If every check passes, the physical address is the entry's frame number with the offset appended. Otherwise the block reports a trap with a two-bit cause.

A request strobe samples the address, the access kind, the entry fields and the page-count limit. One cycle later a single-cycle done pulse appears with the registered result. The result holds until the next request. Looking the entry up in memory, caching entries and choosing which entry to replace are left to surrounding logic.

Top module: `page_xlate`

## Requirements
- R1: With default parameters (14-bit logical address, 11-bit offset), the page number is address bits [13:11] and the offset is address bits [10:0].
- R2: When no fault applies, the physical address equals frame × 2^OFF_W + offset, which is {frame, offset}.
- R3: A page number greater than or equal to the page-count limit gives cause 2'b01 (out of range).
- R4: An in-range page whose entry has the valid flag at 0 gives cause 2'b10 (invalid page).
- R5: Access kind encoding is 00 read, 01 write, 10 instruction fetch, 11 reserved. Rights encoding is 00 read-only, 01 read-write, 10 execute-only, 11 read-execute. A read is allowed under 00, 01 and 11. A write is allowed only under 01. A fetch is allowed only under 10 and 11. A reserved access is never allowed. A disallowed access on a valid, in-range page gives cause 2'b11 (protection).
- R6: When several faults apply, out of range takes precedence over invalid, and invalid takes precedence over protection.
- R7: The fault output is 1 exactly when the cause is nonzero. The physical address is 0 whenever a fault is reported. With no fault, the cause is 2'b00.
- R8: A request sampled on a rising edge gives done = 1 for exactly the following cycle. Without a request, done is 0 and the physical address, fault and cause keep their values.
- R9: While reset is high, and after it, done, fault, cause and the physical address are all 0 until the first request.
- R10: A limit of 2^(LA_W−OFF_W), which is 8 by default, admits every page. A limit of 0 makes every page out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe; samples all request inputs |
| laddr | input | LA_W | Logical address |
| acc | input | 2 | Access kind (R5 encoding) |
| ent_valid | input | 1 | Valid flag of the page-table entry |
| ent_frame | input | FRAME_W | Frame number from the entry |
| ent_rights | input | 2 | Access rights from the entry (R5 encoding) |
| pg_limit | input | LA_W−OFF_W+1 | Number of pages the process owns |
| paddr | output | FRAME_W+OFF_W | Physical address, 0 on fault |
| done | output | 1 | One-cycle pulse one cycle after a request |
| fault | output | 1 | Trap indication |
| cause | output | 2 | Fault cause: 00 none, 01 range, 10 invalid, 11 protection |

## Verification
All state is a single output register stage. A wrong internal value therefore shows at the ports in the very cycle of the done pulse. A bad split or frame merge shows as a wrong physical address. A bad priority or rights decode shows as a wrong cause. The same fault can also leave a nonzero address beside fault = 1. A stale or mis-enabled register shows one cycle after a request-free cycle, as done failing to drop or as outputs changing without a request. Boundary pages at and beyond the limit, together with the full limit and the zero limit, expose off-by-one errors in the range compare at once.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    RIGHTS_RO = 2'b00,
    RIGHTS_RW = 2'b01,
    RIGHTS_XO = 2'b10,
    RIGHTS_RX = 2'b11
  } rights_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_RANGE = 2'b01,
    CAUSE_INVAL = 2'b10,
    CAUSE_PROT  = 2'b11
  } cause_e;
endpackage

// File: rtl/xlate_split.sv
// Cuts the logical address into page number and offset and bounds the page.
module xlate_split #(
  parameter int LA_W  = 14,
  parameter int OFF_W = 11,
  localparam int PG_W  = LA_W - OFF_W,
  localparam int LIM_W = PG_W + 1
) (
  input  logic [LA_W-1:0]  laddr,
  input  logic [LIM_W-1:0] pg_limit,
  output logic [PG_W-1:0]  page,
  output logic [OFF_W-1:0] offset,
  output logic             out_of_range
);
  assign page   = laddr[LA_W-1:OFF_W];
  assign offset = laddr[OFF_W-1:0];
  // R3: page index must be strictly below the owned page count
  assign out_of_range = ({1'b0, page} >= pg_limit);
endmodule

// File: rtl/xlate_rights.sv
// Decides whether an access kind is permitted by the entry's rights field.
module xlate_rights
  import xlate_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [1:0] rights,
  output logic       allow
);
  acc_e    a;
  rights_e r;
  assign a = acc_e'(acc);
  assign r = rights_e'(rights);

  always_comb begin
    allow = 1'b0;
    unique case (a)
      ACC_READ:  allow = (r == RIGHTS_RO) || (r == RIGHTS_RW) || (r == RIGHTS_RX);
      ACC_WRITE: allow = (r == RIGHTS_RW);
      ACC_FETCH: allow = (r == RIGHTS_XO) || (r == RIGHTS_RX);
      ACC_RSVD:  allow = 1'b0;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlate_fault.sv
// Priority encoder for the trap cause: range, then invalid, then protection.
module xlate_fault
  import xlate_pkg::*;
(
  input  logic   out_of_range,
  input  logic   ent_valid,
  input  logic   allow,
  output cause_e cause
);
  always_comb begin
    if (out_of_range)    cause = CAUSE_RANGE;
    else if (!ent_valid) cause = CAUSE_INVAL;
    else if (!allow)     cause = CAUSE_PROT;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/page_xlate.sv
// Paged translator: one register stage between request and result.
module page_xlate
  import xlate_pkg::*;
#(
  parameter int LA_W    = 14,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 8,
  localparam int PG_W  = LA_W - OFF_W,
  localparam int LIM_W = PG_W + 1,
  localparam int PA_W  = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [LA_W-1:0]    laddr,
  input  logic [1:0]         acc,
  input  logic               ent_valid,
  input  logic [FRAME_W-1:0] ent_frame,
  input  logic [1:0]         ent_rights,
  input  logic [LIM_W-1:0]   pg_limit,
  output logic [PA_W-1:0]    paddr,
  output logic               done,
  output logic               fault,
  output logic [1:0]         cause
);
  logic [PG_W-1:0]  page;
  logic [OFF_W-1:0] offset;
  logic             oor;
  logic             allow;
  cause_e           nxt_cause;
  logic [PA_W-1:0]  nxt_paddr;

  xlate_split #(.LA_W(LA_W), .OFF_W(OFF_W)) u_split (
    .laddr        (laddr),
    .pg_limit     (pg_limit),
    .page         (page),
    .offset       (offset),
    .out_of_range (oor)
  );

  xlate_rights u_rights (
    .acc    (acc),
    .rights (ent_rights),
    .allow  (allow)
  );

  xlate_fault u_fault (
    .out_of_range (oor),
    .ent_valid    (ent_valid),
    .allow        (allow),
    .cause        (nxt_cause)
  );

  // Frame concatenated with offset; forced to zero on any trap.
  assign nxt_paddr = (nxt_cause == CAUSE_NONE) ? {ent_frame, offset} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      fault <= 1'b0;
      cause <= 2'b00;
      paddr <= '0;
    end else begin
      done <= req;
      if (req) begin
        cause <= nxt_cause;
        fault <= (nxt_cause != CAUSE_NONE);
        paddr <= nxt_paddr;
      end
    end
  end

  logic unused_page;
  assign unused_page = ^page;
endmodule

// File: rtl/page_xlate_chk.sv
// Temporal properties of the translator, attached by bind.
module page_xlate_chk #(
  parameter int LA_W    = 14,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 8,
  localparam int PG_W  = LA_W - OFF_W,
  localparam int LIM_W = PG_W + 1,
  localparam int PA_W  = FRAME_W + OFF_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic [LA_W-1:0]    laddr,
  input logic [1:0]         acc,
  input logic               ent_valid,
  input logic [FRAME_W-1:0] ent_frame,
  input logic [1:0]         ent_rights,
  input logic [LIM_W-1:0]   pg_limit,
  input logic [PA_W-1:0]    paddr,
  input logic               done,
  input logic               fault,
  input logic [1:0]         cause
);
  logic beyond;
  assign beyond = ({1'b0, laddr[LA_W-1:OFF_W]} >= pg_limit);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    req |=> done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!done && $stable(paddr) && $stable(cause) && $stable(fault)));

  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    (req && beyond) |=> (cause == 2'b01));

  p_invalid_r4: assert property (@(posedge clk) disable iff (rst)
    (req && !beyond && !ent_valid) |=> (cause == 2'b10));

  p_write_ro_r5: assert property (@(posedge clk) disable iff (rst)
    (req && !beyond && ent_valid && acc == 2'b01 && ent_rights != 2'b01)
      |=> (cause == 2'b11));

  p_map_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !beyond && ent_valid && acc == 2'b00 && ent_rights != 2'b10)
      |=> (paddr == {$past(ent_frame), $past(laddr[OFF_W-1:0])} && !fault));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ((fault == (cause != 2'b00)) && (!fault || paddr == '0)));
endmodule

bind page_xlate page_xlate_chk #(
  .LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .laddr(laddr), .acc(acc),
  .ent_valid(ent_valid), .ent_frame(ent_frame), .ent_rights(ent_rights),
  .pg_limit(pg_limit), .paddr(paddr), .done(done), .fault(fault), .cause(cause)
);

// File: tb/test_page_xlate.sv
module test_page_xlate;
  localparam int LA_W = 14, OFF_W = 11, FRAME_W = 8;
  localparam int PG_W = LA_W - OFF_W, LIM_W = PG_W + 1, PA_W = FRAME_W + OFF_W;
  localparam int NV = 17;

  // vector: laddr[32:19] acc[18:17] valid[16] frame[15:8] rights[7:6] limit[5:2] cause[1:0]
  localparam logic [32:0] VECS [NV] = '{
    {14'h1123, 2'd0, 1'b1, 8'h01, 2'd1, 4'd6, 2'd0},  // R1 R2 page2 read RW
    {14'h2FFF, 2'd1, 1'b1, 8'hAB, 2'd1, 4'd6, 2'd0},  // R2 page5 top offset write RW
    {14'h3000, 2'd0, 1'b1, 8'h11, 2'd1, 4'd6, 2'd1},  // R3 page6
    {14'h3ABC, 2'd0, 1'b1, 8'h11, 2'd1, 4'd6, 2'd1},  // R3 page7
    {14'h0005, 2'd0, 1'b0, 8'h22, 2'd1, 4'd6, 2'd2},  // R4 invalid
    {14'h0800, 2'd1, 1'b1, 8'h33, 2'd0, 4'd6, 2'd3},  // R5 write RO
    {14'h0801, 2'd2, 1'b1, 8'h33, 2'd0, 4'd6, 2'd3},  // R5 fetch RO
    {14'h0802, 2'd2, 1'b1, 8'h3C, 2'd2, 4'd6, 2'd0},  // R5 fetch XO
    {14'h0803, 2'd0, 1'b1, 8'h3C, 2'd2, 4'd6, 2'd3},  // R5 read XO
    {14'h0804, 2'd1, 1'b1, 8'h3C, 2'd2, 4'd6, 2'd3},  // R5 write XO
    {14'h1805, 2'd2, 1'b1, 8'h5A, 2'd3, 4'd6, 2'd0},  // R5 fetch RX
    {14'h1806, 2'd1, 1'b1, 8'h5A, 2'd3, 4'd6, 2'd3},  // R5 write RX
    {14'h1007, 2'd3, 1'b1, 8'h5A, 2'd1, 4'd6, 2'd3},  // R5 reserved access
    {14'h3808, 2'd1, 1'b0, 8'h66, 2'd0, 4'd6, 2'd1},  // R6 range beats invalid+prot
    {14'h1009, 2'd1, 1'b0, 8'h66, 2'd0, 4'd6, 2'd2},  // R6 invalid beats prot
    {14'h3FFF, 2'd0, 1'b1, 8'hFF, 2'd1, 4'd8, 2'd0},  // R10 full limit
    {14'h0000, 2'd0, 1'b1, 8'h01, 2'd1, 4'd0, 2'd1}   // R10 zero limit
  };

  logic clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic [LA_W-1:0] laddr = '0;
  logic [1:0] acc = '0, ent_rights = '0, cause;
  logic ent_valid = 1'b0, done, fault;
  logic [FRAME_W-1:0] ent_frame = '0;
  logic [LIM_W-1:0] pg_limit = '0;
  logic [PA_W-1:0] paddr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  page_xlate #(.LA_W(LA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) i_page_xlate (
    .clk(clk), .rst(rst), .req(req), .laddr(laddr), .acc(acc),
    .ent_valid(ent_valid), .ent_frame(ent_frame), .ent_rights(ent_rights),
    .pg_limit(pg_limit), .paddr(paddr), .done(done), .fault(fault), .cause(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [32:0] v);
    @(negedge clk);
    laddr = v[32:19]; acc = v[18:17]; ent_valid = v[16];
    ent_frame = v[15:8]; ent_rights = v[7:6]; pg_limit = v[5:2];
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic expect_res(input logic [32:0] v, input string tag);
    logic [PA_W-1:0] ep;
    ep = (v[1:0] == 2'd0) ? {v[15:8], v[29:19]} : '0;
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " cause"}, 32'(cause), 32'(v[1:0]));
    chk({tag, " R7 fault"}, 32'(fault), 32'(v[1:0] != 2'd0));
    chk({tag, " paddr"}, 32'(paddr), 32'(ep));
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [PA_W-1:0] held;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 32'(done), 0);
    chk("R9 reset fault", 32'(fault), 0);
    chk("R9 reset cause", 32'(cause), 0);
    chk("R9 reset paddr", 32'(paddr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset done", 32'(done), 0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      expect_res(VECS[i], $sformatf("vec%0d", i));
    end

    // R8: no request keeps outputs and drops done
    issue(VECS[0]);
    held = paddr;
    ent_frame = 8'hEE; laddr = 14'h3FFF; pg_limit = 4'd0;
    @(negedge clk);
    chk("R8 done drop", 32'(done), 0);
    chk("R8 paddr hold", 32'(paddr), 32'(held));
    chk("R8 cause hold", 32'(cause), 0);
    @(negedge clk);
    chk("R8 still held", 32'(paddr), 32'(held));

    // R8: back-to-back requests, one result each cycle
    @(negedge clk);
    laddr = 14'h2FFF; acc = 2'd1; ent_valid = 1'b1; ent_frame = 8'hAB;
    ent_rights = 2'd1; pg_limit = 4'd6; req = 1'b1;
    @(negedge clk);
    expect_res(VECS[1], "R8 b2b first");
    laddr = 14'h3000; acc = 2'd0;
    @(negedge clk);
    req = 1'b0;
    expect_res(VECS[2], "R8 b2b second");

    // R1: example page 2 offset 2 in frame 1
    issue({14'h1002, 2'd0, 1'b1, 8'h01, 2'd0, 4'd6, 2'd0});
    chk("R1 R2 example paddr", 32'(paddr), 32'h802);

    // R9: reset clears a faulted result
    issue(VECS[4]);
    chk("R9 pre-reset fault", 32'(fault), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset clears cause", 32'(cause), 0);
    chk("R9 reset clears fault", 32'(fault), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule